// File: doc/BRIEF.md
# Size-Aware IO Window Decoder

This block sits between a CPU data bus and a memory-mapped IO window in the top 32 KiB of a 24-bit address space. Each access carries an address, a size of one, two or four bytes, a read/write strobe, write data and a supervisor flag. The block splits the access into byte lanes, folds aliased addresses onto their home registers, and gives each lane one of four classes: mapped register, silent hole filled with 0xFF, silent hole filled with 0x00, or bus-error hole. It then decides whether the access as a whole faults. A small byte-wide register file stands in for the peripherals behind the mapped ranges.

The fault rule is the core of the block. A byte access to a bus-error address faults. A word or long access faults only when every one of its lanes is a bus-error lane. An access that only partly overlaps bus-error space succeeds, and its bus-error lanes read as 0xFF. Two configuration inputs switch off the block-transfer range and the clock range, and those ranges then behave as holes.

Each request is taken in one cycle. Read data, the bus-error pulse and a done strobe appear after the clock edge that samples the request.

Top module: `io_window_decoder`

## Requirements
- R1: Only bits 23:0 of `addr_i` are decoded. A supervisor access whose 24-bit address is below 0xFF8000 raises `berr_o`.
- R2: An access made with `super_i` low, or below the window, raises `berr_o` and changes no register.
- R3: A lane is checked against the map on its own. `berr_o` is raised only when the count of bus-error lanes equals the access size. A bus-error lane in an access that does not fault reads 0xFF. Every window address not listed in R4, R5, R7 or R8 is a bus-error lane.
- R4: 0xFF8900..0xFF89FF reads 0xFF, and 0xFF8240..0xFF827F reads 0x00. Writes to either range are discarded, and neither range faults.
- R5: Addresses 0xFF8804..0xFF88FF are ANDed with 0xFFF803. They reach the same registers as the four mapped bytes 0xFF8800..0xFF8803, for both reads and writes.
- R6: A word access at 0xFFFFFF, a long access above 0xFFFFFC, and size code 2'b11 are rejected. They give `berr_o` low and `rdata_o` = 0xFFFFFFFF, and they update nothing.
- R7: 0xFF8A00..0xFF8A3F are mapped registers. With `blit_off_i` high they become bus-error lanes, and the stored contents are kept.
- R8: 0xFFFC21..0xFFFC3F are mapped registers. With `clock_off_i` high they read 0xFF and ignore writes. 0xFFFC20 is always a bus-error lane.
- R9: Size codes are 2'b00 byte, 2'b01 word and 2'b10 long. Data is big-endian: the lowest address maps to the most significant byte of the access, which sits at `rdata_o[8*n-1 -: 8]` / `wdata_i[8*n-1 -: 8]` for an n-byte access. Read bits above 8*n are zero.
- R10: `done_o` is high for exactly one cycle after each sampled `req_i`. `berr_o` is only high together with `done_o`. A write that does not fault returns `rdata_o` = 0.
- R11: A faulting access updates no lane of the register file and returns `rdata_o` = 0xFFFFFFFF.
- R12: After reset, `done_o`, `berr_o` and `rdata_o` are zero and every mapped register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | 00 byte, 01 word, 10 long, 11 rejected |
| addr_i | input | 32 | Byte address; only bits 23:0 are used |
| wdata_i | input | 32 | Write data, right-aligned, big-endian |
| super_i | input | 1 | Supervisor mode flag |
| blit_off_i | input | 1 | Turns the block-transfer range into a bus-error hole |
| clock_off_i | input | 1 | Turns the clock range into a 0xFF silent hole |
| done_o | output | 1 | One-cycle completion strobe |
| berr_o | output | 1 | Bus-error pulse, valid with done_o |
| rdata_o | output | 32 | Read data, right-aligned, big-endian |

## Verification
A wrong lane class or a wrong fault count shows on the ports at the next `done_o`. A lost fault shows as `berr_o` low with data present. A false fault shows as `berr_o` high with all-ones data. A wrong fold or a write enable on a faulting access damages register contents, and that stays hidden until a later read of the same byte. For this reason every write scenario reads its target back, or reads it through an alias. Byte swaps from the endian mapping only show when a multi-byte pattern with distinct bytes is read at a different size from the one used to write it.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int ADDR_W = 24;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    CLS_REG     = 2'd0,
    CLS_FILL_FF = 2'd1,
    CLS_FILL_00 = 2'd2,
    CLS_BERR    = 2'd3
  } lane_cls_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;

  localparam logic [ADDR_W-1:0] WIN_LO    = 24'hFF8000;
  localparam logic [ADDR_W-1:0] WORD_MAX  = 24'hFFFFFE;
  localparam logic [ADDR_W-1:0] LONG_MAX  = 24'hFFFFFC;

  localparam logic [ADDR_W-1:0] SND_BASE  = 24'hFF8800;
  localparam int                SND_SPAN  = 4;
  localparam logic [ADDR_W-1:0] MIR_LO    = 24'hFF8804;
  localparam logic [ADDR_W-1:0] MIR_HI    = 24'hFF88FF;
  localparam logic [ADDR_W-1:0] MIR_MASK  = 24'hFFF803;

  localparam logic [ADDR_W-1:0] BLT_BASE  = 24'hFF8A00;
  localparam int                BLT_SPAN  = 64;
  localparam logic [ADDR_W-1:0] CLK_BASE  = 24'hFFFC20;
  localparam int                CLK_SPAN  = 32;

  localparam logic [ADDR_W-1:0] FFH_LO    = 24'hFF8900;
  localparam logic [ADDR_W-1:0] FFH_HI    = 24'hFF89FF;
  localparam logic [ADDR_W-1:0] ZH_LO     = 24'hFF8240;
  localparam logic [ADDR_W-1:0] ZH_HI     = 24'hFF827F;

  function automatic logic [ADDR_W-1:0] fold_mirror(input logic [ADDR_W-1:0] a);
    if (a >= MIR_LO && a <= MIR_HI) return a & MIR_MASK;
    return a;
  endfunction
endpackage

// File: rtl/io_region_map.sv
module io_region_map
  import io_dec_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              blit_off_i,
  input  logic              clock_off_i,
  output lane_cls_e         cls_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] SND_END = SND_BASE + ADDR_W'(SND_SPAN);
  localparam logic [ADDR_W-1:0] BLT_END = BLT_BASE + ADDR_W'(BLT_SPAN);
  localparam logic [ADDR_W-1:0] CLK_END = CLK_BASE + ADDR_W'(CLK_SPAN);
  localparam int SND_OFS = 0;
  localparam int CLK_OFS = CLK_SPAN;
  localparam int BLT_OFS = 2 * CLK_SPAN;

  logic [ADDR_W-1:0] rel;

  always_comb begin
    cls_o = CLS_BERR;
    idx_o = '0;
    rel   = '0;
    if (addr_i >= SND_BASE && addr_i < SND_END) begin
      rel   = addr_i - SND_BASE;
      cls_o = CLS_REG;
      idx_o = IDX_W'(SND_OFS) + IDX_W'(rel);
    end else if (addr_i >= BLT_BASE && addr_i < BLT_END) begin
      rel   = addr_i - BLT_BASE;
      cls_o = blit_off_i ? CLS_BERR : CLS_REG;
      idx_o = IDX_W'(BLT_OFS) + IDX_W'(rel);
    end else if (addr_i > CLK_BASE && addr_i < CLK_END) begin
      rel   = addr_i - CLK_BASE;
      cls_o = clock_off_i ? CLS_FILL_FF : CLS_REG;
      idx_o = IDX_W'(CLK_OFS) + IDX_W'(rel);
    end else if (addr_i >= FFH_LO && addr_i <= FFH_HI) begin
      cls_o = CLS_FILL_FF;
    end else if (addr_i >= ZH_LO && addr_i <= ZH_HI) begin
      cls_o = CLS_FILL_00;
    end
  end
endmodule

// File: rtl/io_fault_eval.sv
module io_fault_eval
  import io_dec_pkg::*;
(
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [1:0]               size_i,
  input  logic                     super_i,
  input  lane_cls_e [LANES-1:0]    cls_i,
  output logic [LANES-1:0]         act_o,
  output logic [2:0]               nbytes_o,
  output logic                     illegal_o,
  output logic                     fault_o
);
  logic [2:0] berr_cnt;
  logic       early_fault;

  always_comb begin
    unique case (size_i)
      SZ_BYTE: nbytes_o = 3'd1;
      SZ_WORD: nbytes_o = 3'd2;
      SZ_LONG: nbytes_o = 3'd4;
      default: nbytes_o = 3'd0;
    endcase
  end

  assign early_fault = !super_i || (addr_i < WIN_LO);
  assign illegal_o   = (size_i == 2'b11)
                     || (size_i == SZ_WORD && addr_i > WORD_MAX)
                     || (size_i == SZ_LONG && addr_i > LONG_MAX);

  always_comb begin
    berr_cnt = '0;
    for (int k = 0; k < LANES; k++) begin
      act_o[k] = (3'(k) < nbytes_o);
      if (act_o[k] && cls_i[k] == CLS_BERR) berr_cnt = berr_cnt + 3'd1;
    end
  end

  // all-lanes rule: partial overlap with bus-error space does not fault
  assign fault_o = early_fault || (!illegal_o && berr_cnt == nbytes_o);
endmodule

// File: rtl/io_lane_regfile.sv
module io_lane_regfile
  import io_dec_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            wr_en_i,
  input  logic [LANES-1:0][IDX_W-1:0] idx_i,
  input  logic [LANES-1:0][7:0]       wr_data_i,
  output logic [LANES-1:0][7:0]       rd_data_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
    end else begin
      for (int k = 0; k < LANES; k++)
        if (wr_en_i[k]) mem_q[idx_i[k]] <= wr_data_i[k];
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) rd_data_o[k] = mem_q[idx_i[k]];
  end
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import io_dec_pkg::*;
#(
  parameter int RF_DEPTH = 128,
  localparam int IDX_W = $clog2(RF_DEPTH)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] addr_i,
  input  logic [31:0] wdata_i,
  input  logic        super_i,
  input  logic        blit_off_i,
  input  logic        clock_off_i,
  output logic        done_o,
  output logic        berr_o,
  output logic [31:0] rdata_o
);
  logic [ADDR_W-1:0]             addr24;
  logic                          unused_addr_hi;
  lane_cls_e [LANES-1:0]         lane_cls;
  logic [LANES-1:0][IDX_W-1:0]   lane_idx;
  logic [LANES-1:0]              lane_act;
  logic [LANES-1:0]              lane_wen;
  logic [LANES-1:0][7:0]         lane_wr;
  logic [LANES-1:0][7:0]         lane_rf;
  logic [LANES-1:0][7:0]         lane_rd;
  logic [2:0]                    nbytes;
  logic                          illegal;
  logic                          fault;
  logic [DATA_W-1:0]             rd_word;

  assign addr24         = addr_i[ADDR_W-1:0];
  assign unused_addr_hi = ^addr_i[31:ADDR_W];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    assign lane_addr = fold_mirror(addr24 + ADDR_W'(k));

    io_region_map #(.IDX_W(IDX_W)) u_map (
      .addr_i      (lane_addr),
      .blit_off_i  (blit_off_i),
      .clock_off_i (clock_off_i),
      .cls_o       (lane_cls[k]),
      .idx_o       (lane_idx[k])
    );

    always_comb begin
      unique case (lane_cls[k])
        CLS_REG:     lane_rd[k] = lane_rf[k];
        CLS_FILL_00: lane_rd[k] = 8'h00;
        default:     lane_rd[k] = 8'hFF;
      endcase
    end

    assign lane_wen[k] = req_i && we_i && !fault && !illegal
                      && lane_act[k] && (lane_cls[k] == CLS_REG);
  end

  io_fault_eval u_fault (
    .addr_i    (addr24),
    .size_i    (size_i),
    .super_i   (super_i),
    .cls_i     (lane_cls),
    .act_o     (lane_act),
    .nbytes_o  (nbytes),
    .illegal_o (illegal),
    .fault_o   (fault)
  );

  // big-endian lane <-> byte position mapping
  always_comb begin
    rd_word = '0;
    for (int k = 0; k < LANES; k++) begin
      lane_wr[k] = 8'h00;
      if (lane_act[k]) begin
        rd_word[8*(int'(nbytes)-1-k) +: 8] = lane_rd[k];
        lane_wr[k] = wdata_i[8*(int'(nbytes)-1-k) +: 8];
      end
    end
  end

  io_lane_regfile #(.DEPTH(RF_DEPTH)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (lane_wen),
    .idx_i     (lane_idx),
    .wr_data_i (lane_wr),
    .rd_data_o (lane_rf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      berr_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= req_i;
      berr_o <= req_i && fault;
      if (req_i) begin
        if (fault || illegal) rdata_o <= '1;
        else if (we_i)        rdata_o <= '0;
        else                  rdata_o <= rd_word;
      end
    end
  end
endmodule

// File: rtl/io_window_decoder_chk.sv
module io_window_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [1:0]  size_i,
  input logic [23:0] addr_i,
  input logic        super_i,
  input logic        done_o,
  input logic        berr_o,
  input logic [31:0] rdata_o
);
  a_r10_done_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  a_r10_done_is_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !done_o);
  a_r10_berr_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> done_o);
  a_r2_user_mode_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !super_i) |=> berr_o);
  a_r1_below_window_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i < 24'hFF8000) |=> berr_o);
  a_r6_bad_size_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && super_i && addr_i >= 24'hFF8000 && size_i == 2'b11)
      |=> (!berr_o && rdata_o == 32'hFFFF_FFFF));
  a_r11_fault_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> rdata_o == 32'hFFFF_FFFF);
  a_r9_byte_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i == 2'b00) |=> (berr_o || rdata_o[31:8] == 24'h0));
endmodule

bind io_window_decoder io_window_decoder_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .size_i  (size_i),
  .addr_i  (addr_i[23:0]),
  .super_i (super_i),
  .done_o  (done_o),
  .berr_o  (berr_o),
  .rdata_o (rdata_o)
);

// File: tb/io_window_decoder_bench.sv
`timescale 1ns/1ps
module io_window_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sup = 1'b1, blit_off = 1'b0, clock_off = 1'b0;
  logic [1:0]  size = 2'b00;
  logic [31:0] addr = '0, wdata = '0;
  logic        done, berr;
  logic [31:0] rdata;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  localparam logic [1:0] B = 2'b00, W = 2'b01, L = 2'b10;

  always #2.5 clk = ~clk;

  io_window_decoder u_io_window_decoder (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .super_i(sup), .blit_off_i(blit_off),
    .clock_off_i(clock_off), .done_o(done), .berr_o(berr), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  logic [31:0] r_d;
  logic        r_b, r_dn;

  task automatic acc(input logic w, input logic [1:0] sz, input logic [31:0] a,
                     input logic [31:0] d, input logic s);
    @(negedge clk);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d; sup = s;
    @(negedge clk);
    req = 1'b0; we = 1'b0; sup = 1'b1;
    r_d = rdata; r_b = berr; r_dn = done;
  endtask

  task automatic rd(input logic [1:0] sz, input logic [31:0] a);
    acc(1'b0, sz, a, 32'h0, 1'b1);
  endtask

  task automatic wr(input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d);
    acc(1'b1, sz, a, d, 1'b1);
  endtask

  task automatic t_reset;
    chk("R12 done after reset", {31'b0, done}, 32'h0);
    chk("R12 berr after reset", {31'b0, berr}, 32'h0);
    chk("R12 rdata after reset", rdata, 32'h0);
    rd(B, 32'h00FF8A05);
    chk("R12 register resets to zero", r_d, 32'h0);
  endtask

  task automatic t_endian;
    wr(L, 32'h00FF8800, 32'h11223344);
    chk("R10 write rdata zero", r_d, 32'h0);
    chk("R10 done on write", {31'b0, r_dn}, 32'h1);
    rd(L, 32'h00FF8800);
    chk("R9 long readback", r_d, 32'h11223344);
    rd(B, 32'h00FF8802);
    chk("R9 byte lane of long", r_d, 32'h00000033);
    wr(W, 32'h00FF8802, 32'h0000ABCD);
    rd(L, 32'h00FF8800);
    chk("R9 word write placement", r_d, 32'h1122ABCD);
    @(negedge clk);
    chk("R10 done drops when idle", {31'b0, done}, 32'h0);
  endtask

  task automatic t_mirror;
    rd(W, 32'h00FF8806);
    chk("R5 mirror word read", r_d, 32'h0000ABCD);
    wr(B, 32'h00FF8845, 32'h0000009C);
    rd(B, 32'h00FF8801);
    chk("R5 mirror write reaches home", r_d, 32'h0000009C);
    rd(L, 32'h00FF8802);
    chk("R5 long straddling mirror", r_d, 32'hABCD119C);
  endtask

  task automatic t_fault_rule;
    wr(B, 32'h00FF8A3F, 32'h00000077);
    rd(W, 32'h00FF8A3F);
    chk("R3 partial overlap no fault", {31'b0, r_b}, 32'h0);
    chk("R3 berr lane reads FF", r_d, 32'h000077FF);
    rd(L, 32'h00FF8A3E);
    chk("R3 long half berr", r_d, 32'h0077FFFF);
    rd(B, 32'h00FF8A40);
    chk("R3 byte on berr faults", {31'b0, r_b}, 32'h1);
    chk("R11 fault data fill", r_d, 32'hFFFFFFFF);
    rd(W, 32'h00FF8A40);
    chk("R3 word all berr faults", {31'b0, r_b}, 32'h1);
    rd(L, 32'h00FFFFFC);
    chk("R3 long all berr faults", {31'b0, r_b}, 32'h1);
    rd(B, 32'h00FF8000);
    chk("R3 unlisted address faults", {31'b0, r_b}, 32'h1);
  endtask

  task automatic t_privilege;
    acc(1'b1, B, 32'h00FF8800, 32'h000000EE, 1'b0);
    chk("R2 user write faults", {31'b0, r_b}, 32'h1);
    rd(B, 32'h00FF8800);
    chk("R11 faulting write left reg", r_d, 32'h00000011);
    acc(1'b0, B, 32'h00FF8800, 32'h0, 1'b0);
    chk("R2 user read faults", {31'b0, r_b}, 32'h1);
    rd(B, 32'h00FF7FFF);
    chk("R1 below window faults", {31'b0, r_b}, 32'h1);
    rd(B, 32'hABFF8801);
    chk("R1 upper address bits ignored", r_d, 32'h0000009C);
    chk("R1 no fault when truncated in window", {31'b0, r_b}, 32'h0);
  endtask

  task automatic t_holes;
    wr(B, 32'h00FF8900, 32'h00000012);
    chk("R4 hole write no fault", {31'b0, r_b}, 32'h0);
    rd(B, 32'h00FF8900);
    chk("R4 FF hole read", r_d, 32'h000000FF);
    rd(W, 32'h00FF8240);
    chk("R4 zero hole read", r_d, 32'h00000000);
    chk("R4 zero hole no fault", {31'b0, r_b}, 32'h0);
    rd(W, 32'h00FF823F);
    chk("R3 berr lane next to zero hole", r_d, 32'h0000FF00);
  endtask

  task automatic t_illegal;
    rd(W, 32'h00FFFFFF);
    chk("R6 word at top no berr", {31'b0, r_b}, 32'h0);
    chk("R6 word at top data", r_d, 32'hFFFFFFFF);
    rd(L, 32'h00FFFFFD);
    chk("R6 long past limit", {r_b, r_d[30:0]}, 32'h7FFFFFFF);
    acc(1'b1, 2'b11, 32'h00FF8800, 32'h55555555, 1'b1);
    chk("R6 size 3 no berr", {31'b0, r_b}, 32'h0);
    rd(L, 32'h00FF8800);
    chk("R6 size 3 write ignored", r_d, 32'h119CABCD);
  endtask

  task automatic t_blit_cfg;
    wr(B, 32'h00FF8A10, 32'h000000AB);
    blit_off = 1'b1;
    rd(B, 32'h00FF8A10);
    chk("R7 disabled range faults", {31'b0, r_b}, 32'h1);
    wr(B, 32'h00FF8A10, 32'h00000011);
    chk("R7 disabled write faults", {31'b0, r_b}, 32'h1);
    blit_off = 1'b0;
    rd(B, 32'h00FF8A10);
    chk("R7 contents kept", r_d, 32'h000000AB);
  endtask

  task automatic t_clock_cfg;
    wr(B, 32'h00FFFC21, 32'h0000003C);
    rd(B, 32'h00FFFC21);
    chk("R8 clock reg readback", r_d, 32'h0000003C);
    clock_off = 1'b1;
    rd(B, 32'h00FFFC21);
    chk("R8 disabled reads FF", r_d, 32'h000000FF);
    chk("R8 disabled no fault", {31'b0, r_b}, 32'h0);
    wr(B, 32'h00FFFC21, 32'h00000000);
    clock_off = 1'b0;
    rd(B, 32'h00FFFC21);
    chk("R8 disabled write ignored", r_d, 32'h0000003C);
    rd(B, 32'h00FFFC20);
    chk("R8 base byte faults", {31'b0, r_b}, 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_endian;
    t_mirror;
    t_fault_rule;
    t_privilege;
    t_holes;
    t_illegal;
    t_blit_cfg;
    t_clock_cfg;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule